// File: doc/BRIEF.md
# Full-Speed Serial Bus Line Receiver

This block is the bit-level receive path of a 12 Mbit/s differential serial bus. It takes the two raw data lines, passes each through a two-flop synchroniser, and reduces the line to one of three states: J, K or single-ended zero. A sampling phase running at four clocks per bit is pulled back into line on every change of line state. The sampled states are NRZI-decoded and the zero bits that the transmitter inserts are stripped out. Packet framing is also found here: the start pattern, the end-of-packet marker and the long single-ended-zero bus reset.

A packet is accepted only after the eight-sample start pattern. From then on every delivered data bit is strobed out, and whole bytes are assembled least significant bit first with their own strobe. Reception ends on an end-of-packet marker or on a stuffing violation. Each of these raises a one-cycle flag and returns the block to hunting for the next start pattern. A separate counter watches for a bus reset, which is reported as a level and is independent of packet reception.

Top module: `usb_fs_rx`

## Requirements
- R1: With the data lines as {dp_i, dm_i}, the code 10 is J, 01 is K, and 00 is single-ended zero. The code 11 is also treated as single-ended zero. Both lines pass through a two-flop synchroniser before they are classified.
- R2: Each sampled J/K state is NRZI-decoded. A state that differs from the previous sampled J/K state gives 0, and an equal state gives 1. Delivered bits fill bytes least significant bit first. byte_vld_o pulses for one cycle with byte_o holding the completed byte, in the same cycle as the eighth bit's bit_vld_o.
- R3: Reception starts only after the samples K J K J K J K K, oldest first. Any other sequence delivers no bits, no bytes and no end-of-packet.
- R4: During reception, the bit that follows six consecutive decoded ones is a 0. That bit is discarded and is not delivered on bit_o or counted into a byte.
- R5: During reception, a decoded 1 that follows six consecutive ones pulses stuff_err_o for one cycle and aborts the packet. rx_active_o falls, no end-of-packet is flagged for that packet, and nothing more is delivered until a new start pattern.
- R6: Two consecutive single-ended-zero bit samples during reception pulse eop_o for one cycle and end reception. A partly filled byte is discarded.
- R7: bus_rst_o is high while the synchronised lines have been single-ended zero for at least RESET_CYCLES clocks (default 480000, 10 ms at 48 MHz). It is low otherwise, and it never raises eop_o outside a packet.
- R8: Each bit lasts four clocks. The sampling phase restarts at every change of line state. A bit that begins at a transition may be one clock shorter or longer than four clocks without corrupting the data.
- R9: bit_vld_o pulses once per delivered data bit, and only while rx_active_o is high. A packet of N data bits yields exactly N strobes.
- R10: After reset, bit_vld_o, byte_vld_o, eop_o, stuff_err_o, bus_rst_o and rx_active_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | Raw positive data line |
| dm_i | input | 1 | Raw negative data line |
| bit_o | output | 1 | Delivered data bit |
| bit_vld_o | output | 1 | Strobe for bit_o |
| byte_o | output | DW | Assembled byte, least significant bit received first |
| byte_vld_o | output | 1 | Strobe for byte_o |
| eop_o | output | 1 | End-of-packet pulse |
| stuff_err_o | output | 1 | Stuffing violation pulse; packet aborted |
| bus_rst_o | output | 1 | Long single-ended-zero bus reset level |
| rx_active_o | output | 1 | High between start pattern and packet end |

## Verification
Fixed byte patterns separate the decoding paths. Alternating values exercise both NRZI outcomes. All-ones bytes force stuffed zeros, which catches a receiver that delivers them or counts the run wrongly. All-zero bytes give a transition on every bit. Seeded random packets have bit lengths of three to five clocks at transitions, which tests whether the sampling phase really re-centres. Directed cases cover a start pattern that is one sample short, a packet ending on the 11 line code, a packet ending mid-byte, a missing stuffed zero, and a long single-ended zero held on either side of the reset threshold.

// File: rtl/usb_fs_rx_pkg.sv
package usb_fs_rx_pkg;
  // Line state coded as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10
  } line_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } rx_st_t;

  localparam int SYNC_LEN = 8;
  // 1 = K, oldest sample in the MSB: K J K J K J K K
  localparam logic [SYNC_LEN-1:0] SYNC_PAT = 8'b1010_1011;
endpackage

// File: rtl/usb_fs_rx_front.sv
module usb_fs_rx_front
  import usb_fs_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_t ls_o
);
  logic [SYNC_STAGES-1:0] dp_s, dm_s;
  logic                   dp_q, dm_q;
  line_t                  cls;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_s <= '1;
      dm_s <= '0;
    end else begin
      dp_s <= {dp_s[SYNC_STAGES-2:0], dp_i};
      dm_s <= {dm_s[SYNC_STAGES-2:0], dm_i};
    end
  end

  assign dp_q = dp_s[SYNC_STAGES-1];
  assign dm_q = dm_s[SYNC_STAGES-1];

  // both lines equal: single-ended condition
  always_comb begin
    if (dp_q == dm_q)  cls = LS_SE0;
    else if (dp_q)     cls = LS_J;
    else               cls = LS_K;
  end

  always_ff @(posedge clk) begin
    if (rst) ls_o <= LS_J;
    else     ls_o <= cls;
  end
endmodule

// File: rtl/usb_fs_rx_bitclk.sv
module usb_fs_rx_bitclk
  import usb_fs_rx_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t ls_i,
  output logic  smp_o,
  output line_t smp_ls_o
);
  localparam int PW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] MID  = PW'(OVS / 2);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);

  line_t         prev_q;
  logic [PW-1:0] ph_q, ph_nxt;

  // phase restarts on every change of line state
  always_comb begin
    if (ls_i != prev_q)    ph_nxt = '0;
    else if (ph_q == LAST) ph_nxt = '0;
    else                   ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= LS_J;
      ph_q     <= '0;
      smp_o    <= 1'b0;
      smp_ls_o <= LS_J;
    end else begin
      prev_q   <= ls_i;
      ph_q     <= ph_nxt;
      smp_o    <= (ph_nxt == MID);
      smp_ls_o <= ls_i;
    end
  end
endmodule

// File: rtl/usb_fs_rx_decode.sv
module usb_fs_rx_decode
  import usb_fs_rx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RUN_MAX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_i,
  input  line_t         smp_ls_i,
  output logic          bit_o,
  output logic          bit_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          byte_vld_o,
  output logic          eop_o,
  output logic          stuff_err_o,
  output logic          active_o
);
  localparam int BCW = (DW > 2) ? $clog2(DW) : 1;
  localparam int RCW = $clog2(RUN_MAX + 1);

  rx_st_t              st_q;
  line_t               last_q;
  logic                se0_q;
  logic [SYNC_LEN-1:0] win_q, win_nxt;
  logic [RCW-1:0]      ones_q;
  logic [BCW-1:0]      bcnt_q;
  logic [DW-1:0]       sr_q, sr_nxt;
  logic                is_k, nrzi_one;

  assign is_k     = (smp_ls_i == LS_K);
  assign nrzi_one = (smp_ls_i == last_q);
  assign win_nxt  = {win_q[SYNC_LEN-2:0], is_k};
  assign sr_nxt   = {nrzi_one, sr_q[DW-1:1]};
  assign active_o = (st_q == ST_RECV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_HUNT;
      last_q      <= LS_J;
      se0_q       <= 1'b0;
      win_q       <= '0;
      ones_q      <= '0;
      bcnt_q      <= '0;
      sr_q        <= '0;
      bit_o       <= 1'b0;
      bit_vld_o   <= 1'b0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      eop_o       <= 1'b0;
      stuff_err_o <= 1'b0;
    end else begin
      bit_vld_o   <= 1'b0;
      byte_vld_o  <= 1'b0;
      eop_o       <= 1'b0;
      stuff_err_o <= 1'b0;
      if (smp_i) begin
        if (smp_ls_i == LS_SE0) begin
          win_q  <= '0;
          last_q <= LS_J;
          if (st_q == ST_RECV) begin
            if (se0_q) begin
              eop_o <= 1'b1;
              st_q  <= ST_HUNT;
              se0_q <= 1'b0;
            end else begin
              se0_q <= 1'b1;
            end
          end
        end else begin
          last_q <= smp_ls_i;
          if (st_q == ST_HUNT) begin
            if (win_nxt == SYNC_PAT) begin
              st_q   <= ST_RECV;
              win_q  <= '0;
              ones_q <= RCW'(1);
              bcnt_q <= '0;
              se0_q  <= 1'b0;
            end else begin
              win_q <= win_nxt;
            end
          end else if (se0_q) begin
            // lone single-ended bit: drop the packet silently
            st_q  <= ST_HUNT;
            se0_q <= 1'b0;
            win_q <= {{(SYNC_LEN-1){1'b0}}, is_k};
          end else if (ones_q == RCW'(RUN_MAX)) begin
            if (nrzi_one) begin
              stuff_err_o <= 1'b1;
              st_q        <= ST_HUNT;
              win_q       <= {{(SYNC_LEN-1){1'b0}}, is_k};
            end else begin
              ones_q <= '0;
            end
          end else begin
            bit_o     <= nrzi_one;
            bit_vld_o <= 1'b1;
            ones_q    <= nrzi_one ? ones_q + 1'b1 : '0;
            sr_q      <= sr_nxt;
            if (bcnt_q == BCW'(DW - 1)) begin
              bcnt_q     <= '0;
              byte_o     <= sr_nxt;
              byte_vld_o <= 1'b1;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/usb_fs_rx_busrst.sv
module usb_fs_rx_busrst
  import usb_fs_rx_pkg::*;
#(
  parameter int LIMIT = 480000
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t ls_i,
  output logic  bus_rst_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          se0;

  assign se0 = (ls_i == LS_SE0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      bus_rst_o <= 1'b0;
    end else begin
      if (!se0)                     cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
      bus_rst_o <= se0 && (cnt_q >= CW'(LIMIT - 1));
    end
  end
endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx
  import usb_fs_rx_pkg::*;
#(
  parameter int OVS          = 4,
  parameter int DW           = 8,
  parameter int RUN_MAX      = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_CYCLES = 480000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dp_i,
  input  logic          dm_i,
  output logic          bit_o,
  output logic          bit_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          byte_vld_o,
  output logic          eop_o,
  output logic          stuff_err_o,
  output logic          bus_rst_o,
  output logic          rx_active_o
);
  line_t ls;
  line_t smp_ls;
  logic  smp;

  usb_fs_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk (clk),
    .rst (rst),
    .dp_i(dp_i),
    .dm_i(dm_i),
    .ls_o(ls)
  );

  usb_fs_rx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .ls_i    (ls),
    .smp_o   (smp),
    .smp_ls_o(smp_ls)
  );

  usb_fs_rx_decode #(.DW(DW), .RUN_MAX(RUN_MAX)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .smp_i      (smp),
    .smp_ls_i   (smp_ls),
    .bit_o      (bit_o),
    .bit_vld_o  (bit_vld_o),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .eop_o      (eop_o),
    .stuff_err_o(stuff_err_o),
    .active_o   (rx_active_o)
  );

  usb_fs_rx_busrst #(.LIMIT(RESET_CYCLES)) u_busrst (
    .clk      (clk),
    .rst      (rst),
    .ls_i     (ls),
    .bus_rst_o(bus_rst_o)
  );
endmodule

// File: rtl/usb_fs_rx_chk.sv
module usb_fs_rx_chk (
  input logic clk,
  input logic rst,
  input logic bit_vld_o,
  input logic byte_vld_o,
  input logic eop_o,
  input logic stuff_err_o,
  input logic rx_active_o
);
  assert_bit_in_pkt_R9: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |-> rx_active_o);

  assert_byte_on_bit_R2: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> bit_vld_o);

  assert_eop_ends_R6: assert property (@(posedge clk) disable iff (rst)
    eop_o |-> !rx_active_o);

  assert_eop_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    eop_o |=> !eop_o);

  assert_serr_ends_R5: assert property (@(posedge clk) disable iff (rst)
    stuff_err_o |-> !rx_active_o);

  assert_serr_no_eop_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eop_o, stuff_err_o}));

  assert_bit_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |=> !bit_vld_o);
endmodule

bind usb_fs_rx usb_fs_rx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_vld_o  (bit_vld_o),
  .byte_vld_o (byte_vld_o),
  .eop_o      (eop_o),
  .stuff_err_o(stuff_err_o),
  .rx_active_o(rx_active_o)
);

// File: tb/usb_fs_rx_tb.sv
module usb_fs_rx_tb;
  localparam int RST_CYC = 300;
  localparam logic [1:0] C_J = 2'b10, C_K = 2'b01, C_SE0 = 2'b00, C_SE1 = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp_i = 1'b1, dm_i = 1'b0;
  logic bit_o, bit_vld_o, byte_vld_o, eop_o, stuff_err_o, bus_rst_o, rx_active_o;
  logic [7:0] byte_o;

  int checks = 0, errors = 0;
  int ngot = 0, nbits = 0, neop = 0, nserr = 0;
  logic [7:0] got [0:63];
  logic [7:0] txb [0:63];
  logic [1:0] cur = 2'b10;
  bit jit = 1'b0;
  int delivered = 0;

  always #10 clk = ~clk;

  usb_fs_rx #(.RESET_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rst(rst), .dp_i(dp_i), .dm_i(dm_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .byte_o(byte_o),
    .byte_vld_o(byte_vld_o), .eop_o(eop_o), .stuff_err_o(stuff_err_o),
    .bus_rst_o(bus_rst_o), .rx_active_o(rx_active_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld_o && ngot < 64) begin got[ngot] = byte_o; ngot++; end
      if (bit_vld_o)   nbits++;
      if (eop_o)       neop++;
      if (stuff_err_o) nserr++;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    ngot = 0; nbits = 0; neop = 0; nserr = 0;
  endtask

  task automatic drive(input logic [1:0] c, input int cyc);
    {dp_i, dm_i} = c;
    repeat (cyc) @(negedge clk);
  endtask

  // one bit period of a line level; jitter only on the first bit after a change
  task automatic send_lvl(input logic [1:0] lvl);
    int len;
    len = 4;
    if (jit && lvl != cur) len = 3 + int'($urandom % 3);
    cur = lvl;
    drive(lvl, len);
  endtask

  task automatic send_nrzi(input bit b);
    if (!b) send_lvl((cur == C_J) ? C_K : C_J);
    else    send_lvl(cur);
  endtask

  task automatic send_sync();
    for (int i = 0; i < 8; i++) send_lvl((i % 2 == 0 || i == 7) ? C_K : C_J);
  endtask

  // packet of n data bits from txb, optional missing stuff bit, then end marker
  task automatic send_pkt(input int n, input bit inject, input logic [1:0] end_code);
    int ones;
    bit b;
    bit aborted;
    aborted = 1'b0;
    delivered = 0;
    for (int i = 0; i < 3; i++) send_lvl(C_J);
    send_sync();
    ones = 1;
    for (int i = 0; i < n && !aborted; i++) begin
      b = txb[i/8][i%8];
      if (ones == 6) begin
        if (inject) begin send_nrzi(1'b1); aborted = 1'b1; end
        else begin send_nrzi(1'b0); ones = 0; end
      end
      if (!aborted) begin
        send_nrzi(b);
        ones = b ? ones + 1 : 0;
        delivered++;
      end
    end
    if (!aborted && ones == 6) send_nrzi(1'b0);
    cur = C_SE0;
    drive(end_code, 8);
    cur = C_J;
    drive(C_J, 4);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_pkt(input string req, input int exp_bytes, input int exp_bits,
                           input int exp_eop, input int exp_serr);
    chk(req, ngot, exp_bytes, "byte count");
    for (int i = 0; i < exp_bytes && i < ngot; i++)
      chk(req, int'(got[i]), int'(txb[i]), "byte value");
    chk("R9", nbits, exp_bits, "bit strobes");
    chk("R6", neop, exp_eop, "end-of-packet pulses");
    chk("R5", nserr, exp_serr, "stuffing error pulses");
    chk("R6", int'(rx_active_o), 0, "active after packet");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", int'({bit_vld_o, byte_vld_o, eop_o, stuff_err_o, bus_rst_o, rx_active_o}), 0,
        "outputs after reset");
    drive(C_J, 12);

    // R2 R3 alternating patterns
    clear_mon();
    txb[0] = 8'hA5; txb[1] = 8'h3C;
    send_pkt(16, 1'b0, C_SE0);
    check_pkt("R2", 2, 16, 1, 0);

    // R4 all ones forces stuffed zeros
    clear_mon();
    txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'hFF;
    send_pkt(24, 1'b0, C_SE0);
    check_pkt("R4", 3, 24, 1, 0);

    // R2 all zeros, transition every bit
    clear_mon();
    txb[0] = 8'h00; txb[1] = 8'h00;
    send_pkt(16, 1'b0, C_SE0);
    check_pkt("R2", 2, 16, 1, 0);

    // R6 packet ending mid-byte: partial byte dropped
    clear_mon();
    txb[0] = 8'h5A; txb[1] = 8'h0F;
    send_pkt(12, 1'b0, C_SE0);
    check_pkt("R6", 1, 12, 1, 0);

    // R1 end marker on code 11 also counts as single-ended
    clear_mon();
    txb[0] = 8'hC3;
    send_pkt(8, 1'b0, C_SE1);
    check_pkt("R1", 1, 8, 1, 0);

    // R5 missing stuffed zero: 0x12 then 0xFF, violation after 14 bits
    clear_mon();
    txb[0] = 8'h12; txb[1] = 8'hFF; txb[2] = 8'hFF;
    send_pkt(24, 1'b1, C_SE0);
    chk("R5", delivered, 14, "bench delivered bits");
    check_pkt("R5", 1, 14, 0, 1);

    // R3 start pattern without final K K: nothing received
    clear_mon();
    for (int i = 0; i < 6; i++) send_lvl((i % 2 == 0) ? C_K : C_J);
    for (int i = 0; i < 6; i++) send_nrzi(1'b0);
    cur = C_SE0; drive(C_SE0, 8); cur = C_J; drive(C_J, 16);
    chk("R3", ngot, 0, "bytes without start pattern");
    chk("R3", nbits, 0, "bits without start pattern");
    chk("R3", neop, 0, "eop without start pattern");

    // R8 random packets with bit-length jitter at transitions
    jit = 1'b1;
    for (int p = 0; p < 20; p++) begin
      int nb;
      nb = 1 + int'($urandom % 6);
      for (int i = 0; i < nb; i++) txb[i] = 8'($urandom);
      if (p % 5 == 0) txb[0] = 8'hFF;
      clear_mon();
      send_pkt(nb * 8, 1'b0, C_SE0);
      check_pkt("R8", nb, nb * 8, 1, 0);
    end
    jit = 1'b0;

    // R7 long single-ended zero
    clear_mon();
    cur = C_SE0;
    drive(C_SE0, RST_CYC - 20);
    chk("R7", int'(bus_rst_o), 0, "bus reset before threshold");
    drive(C_SE0, 40);
    chk("R7", int'(bus_rst_o), 1, "bus reset after threshold");
    cur = C_J;
    drive(C_J, 10);
    chk("R7", int'(bus_rst_o), 0, "bus reset after release");
    chk("R7", neop, 0, "no eop from idle reset");

    // R5 recovery: normal packet after everything
    clear_mon();
    txb[0] = 8'h81;
    send_pkt(8, 1'b0, C_SE0);
    check_pkt("R2", 1, 8, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule